// File: doc/BRIEF.md
# DMA Wishbone Width and Pipelining Bridge

This bridge lets a narrow DMA master reach a wide shared system bus. The master side is 32 bits wide and uses classic Wishbone: it raises `up_cyc` and `up_stb` together with a request and holds all of it until `up_ack` comes back. The system side is 64 bits wide and uses pipelined Wishbone. There, a request counts as accepted in the single cycle in which `dn_stb` is high and `dn_stall` is low. The matching `dn_ack` can come any number of cycles later.

The upstream address is a 32-bit-word address. Its bit 0 picks which 32-bit lane of the 64-bit word is used, and the remaining bits form the 64-bit-word address downstream. When a request is captured, the bridge copies the write data onto every lane and steers the byte selects into the chosen lane. When the read data returns, the bridge takes the chosen lane and registers it together with the acknowledge. A controller with four states runs the exchange:

- `ST_IDLE` moves to `ST_ISSUE` when an upstream request is seen, and the request is registered on that transition.
- `ST_ISSUE` drives the downstream strobe and moves to `ST_WAIT` once the strobe is accepted.
- `ST_WAIT` moves to `ST_RESP` when `dn_ack` arrives, and the read data is registered on that transition.
- `ST_RESP` drives the one-cycle upstream acknowledge and moves back to `ST_IDLE`.

Only one transfer is ever in flight. A master that withdraws `up_cyc` before the downstream response arrives gets no acknowledge for that transfer. The downstream side still completes the transfer.

Top module: `dmab_bridge`

## Requirements
- R1: While `rst_n` is low and after it is released, `dn_cyc`, `dn_stb` and `up_ack` are low until a request arrives.
- R2: A request seen in `ST_IDLE` produces `dn_stb` in the next cycle. `dn_adr` equals `up_adr` with its bit 0 removed, so `dn_adr = up_adr >> 1`.
- R3: When `up_adr[0]` is 0, `up_sel` appears on `dn_sel[3:0]` and `dn_sel[7:4]` is zero. When `up_adr[0]` is 1, `up_sel` appears on `dn_sel[7:4]` and `dn_sel[3:0]` is zero.
- R4: `dn_wdat` carries `up_wdat` in both halves, so `{up_wdat, up_wdat}`. `dn_we` equals `up_we`.
- R5: While `dn_stall` is high, `dn_stb` stays high and the request fields stay unchanged. In the cycle after acceptance, `dn_stb` is low. `dn_cyc` stays high from the strobe until `dn_ack`.
- R6: On a read, `up_rdat` is `dn_rdat[31:0]` when `up_adr[0]` is 0 and `dn_rdat[63:32]` when it is 1. `up_rdat` is valid while `up_ack` is high.
- R7: `up_ack` is high for exactly one cycle, and that cycle is the one right after the cycle in which `dn_ack` was high.
- R8: No new downstream strobe is issued while a transfer is pending downstream or while its upstream acknowledge is being delivered.
- R9: If `up_cyc` is low in any cycle between capture and `dn_ack`, that transfer produces no `up_ack`. The downstream transfer still completes, and the next transfer receives its own acknowledge and its own data.
- R10: Count from the cycle in which the request is first presented to the cycle in which `up_ack` is high. This count is the number of stall cycles plus the downstream acknowledge latency plus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_cyc | input | 1 | Upstream bus cycle |
| up_stb | input | 1 | Upstream strobe |
| up_we | input | 1 | Upstream write enable |
| up_adr | input | AW (30) | Upstream 32-bit-word address |
| up_sel | input | 4 | Upstream byte selects |
| up_wdat | input | 32 | Upstream write data |
| up_ack | output | 1 | Upstream acknowledge, one cycle |
| up_rdat | output | 32 | Upstream read data |
| dn_cyc | output | 1 | Downstream bus cycle |
| dn_stb | output | 1 | Downstream strobe |
| dn_we | output | 1 | Downstream write enable |
| dn_adr | output | AW-1 (29) | Downstream 64-bit-word address |
| dn_sel | output | 8 | Downstream byte selects |
| dn_wdat | output | 64 | Downstream write data |
| dn_stall | input | 1 | Downstream stall |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdat | input | 64 | Downstream read data |

## Verification
Suppose the controller holds a wrong state. If it stays in `ST_ISSUE`, a second strobe or a second accepted request appears on the port in the very next cycle. If it never leaves `ST_RESP`, `up_ack` is stretched past one cycle. A lane register that is latched at the wrong time shows up as a wrong read half in the same cycle as `up_ack`. A stale abandon flag shows up on the following transfer, either as a missing acknowledge or as an acknowledge that arrives early with the data of the withdrawn transfer. The scoreboard compares every accepted downstream request and every returned read word, so each of these faults is caught within one transfer.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

    // Controller states for the bridge
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } dmab_state_e;

endpackage

// File: rtl/dmab_req_stage.sv
// Widens the upstream request and holds it for the downstream side.
module dmab_req_stage #(
    parameter int AW    = 30,
    parameter int UP_DW = 32,
    parameter int LANES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      up_we,
    input  logic [AW-1:0]             up_adr,
    input  logic [UP_DW/8-1:0]        up_sel,
    input  logic [UP_DW-1:0]          up_wdat,
    output logic                      dn_we,
    output logic [AW-$clog2(LANES)-1:0] dn_adr,
    output logic [UP_DW*LANES/8-1:0]  dn_sel,
    output logic [UP_DW*LANES-1:0]    dn_wdat,
    output logic [$clog2(LANES)-1:0]  lane_q
);
    localparam int SW  = UP_DW / 8;
    localparam int DW  = UP_DW * LANES;
    localparam int DSW = DW / 8;
    localparam int LB  = $clog2(LANES);
    localparam int DAW = AW - LB;

    logic [LB-1:0]  lane_w;
    logic [DSW-1:0] sel_w;
    logic [DW-1:0]  wdat_w;

    assign lane_w = up_adr[LB-1:0];

    // One slice per lane: copy the data, steer the selects
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign sel_w[g*SW +: SW]        = (lane_w == LB'(g)) ? up_sel : '0;
            assign wdat_w[g*UP_DW +: UP_DW] = up_wdat;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dn_we   <= 1'b0;
            dn_adr  <= '0;
            dn_sel  <= '0;
            dn_wdat <= '0;
            lane_q  <= '0;
        end else if (load) begin
            dn_we   <= up_we;
            dn_adr  <= up_adr[AW-1:LB];
            dn_sel  <= sel_w;
            dn_wdat <= wdat_w;
            lane_q  <= lane_w;
        end
    end

    logic unused_daw;
    assign unused_daw = (DAW > 0);

endmodule

// File: rtl/dmab_resp_stage.sv
// Picks the addressed lane of the returning word and registers it.
module dmab_resp_stage #(
    parameter int UP_DW = 32,
    parameter int LANES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [$clog2(LANES)-1:0] lane,
    input  logic [UP_DW*LANES-1:0]   dn_rdat,
    output logic [UP_DW-1:0]         up_rdat
);
    logic [UP_DW-1:0] part [LANES];

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_part
            assign part[g] = dn_rdat[g*UP_DW +: UP_DW];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_rdat <= '0;
        end else if (load) begin
            up_rdat <= part[lane];
        end
    end

endmodule

// File: rtl/dmab_ctrl.sv
// Converts the classic handshake into a pipelined one, one transfer at a time.
module dmab_ctrl
    import dmab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_cyc,
    input  logic up_stb,
    input  logic dn_stall,
    input  logic dn_ack,
    output logic load_req,
    output logic load_rsp,
    output logic dn_cyc,
    output logic dn_stb,
    output logic up_ack
);
    dmab_state_e state_q, state_d;
    logic        drop_q;   // master withdrew during this transfer
    logic        ack_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (up_cyc && up_stb) state_d = ST_ISSUE;
            ST_ISSUE: if (!dn_stall)        state_d = ST_WAIT;
            ST_WAIT:  if (dn_ack)           state_d = ST_RESP;
            ST_RESP:                        state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        load_req = 1'b0;
        load_rsp = 1'b0;
        dn_cyc   = 1'b0;
        dn_stb   = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_req = up_cyc && up_stb;
            ST_ISSUE: begin dn_cyc = 1'b1; dn_stb = 1'b1; end
            ST_WAIT:  begin dn_cyc = 1'b1; load_rsp = dn_ack; end
            ST_RESP:  ;
            default:  ;
        endcase
    end

    // Abandon tracking and registered acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            if (load_req)
                drop_q <= 1'b0;
            else if (dn_cyc && !up_cyc)
                drop_q <= 1'b1;
            ack_q <= load_rsp && !drop_q && up_cyc;
        end
    end

    assign up_ack = ack_q;

endmodule

// File: rtl/dmab_bridge.sv
// Top: 32-bit classic master to 64-bit pipelined bus, registered both ways.
module dmab_bridge #(
    parameter int AW    = 30,
    parameter int UP_DW = 32,
    parameter int LANES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            up_cyc,
    input  logic                            up_stb,
    input  logic                            up_we,
    input  logic [AW-1:0]                   up_adr,
    input  logic [UP_DW/8-1:0]              up_sel,
    input  logic [UP_DW-1:0]                up_wdat,
    output logic                            up_ack,
    output logic [UP_DW-1:0]                up_rdat,
    output logic                            dn_cyc,
    output logic                            dn_stb,
    output logic                            dn_we,
    output logic [AW-$clog2(LANES)-1:0]     dn_adr,
    output logic [UP_DW*LANES/8-1:0]        dn_sel,
    output logic [UP_DW*LANES-1:0]          dn_wdat,
    input  logic                            dn_stall,
    input  logic                            dn_ack,
    input  logic [UP_DW*LANES-1:0]          dn_rdat
);
    localparam int LB = $clog2(LANES);

    logic          load_req;
    logic          load_rsp;
    logic [LB-1:0] lane_q;

    dmab_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_cyc   (up_cyc),
        .up_stb   (up_stb),
        .dn_stall (dn_stall),
        .dn_ack   (dn_ack),
        .load_req (load_req),
        .load_rsp (load_rsp),
        .dn_cyc   (dn_cyc),
        .dn_stb   (dn_stb),
        .up_ack   (up_ack)
    );

    dmab_req_stage #(.AW(AW), .UP_DW(UP_DW), .LANES(LANES)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_req),
        .up_we   (up_we),
        .up_adr  (up_adr),
        .up_sel  (up_sel),
        .up_wdat (up_wdat),
        .dn_we   (dn_we),
        .dn_adr  (dn_adr),
        .dn_sel  (dn_sel),
        .dn_wdat (dn_wdat),
        .lane_q  (lane_q)
    );

    dmab_resp_stage #(.UP_DW(UP_DW), .LANES(LANES)) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_rsp),
        .lane    (lane_q),
        .dn_rdat (dn_rdat),
        .up_rdat (up_rdat)
    );

endmodule

// File: rtl/dmab_chk.sv
// Protocol checker bound to the bridge top.
module dmab_chk #(
    parameter int AW    = 30,
    parameter int UP_DW = 32,
    parameter int LANES = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        up_ack,
    input logic                        dn_cyc,
    input logic                        dn_stb,
    input logic                        dn_stall,
    input logic                        dn_ack,
    input logic [AW-$clog2(LANES)-1:0] dn_adr,
    input logic [UP_DW*LANES/8-1:0]    dn_sel,
    input logic [UP_DW*LANES-1:0]      dn_wdat
);
    localparam int SW = UP_DW / 8;

    logic [LANES-1:0] lane_nz;
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_nz
            assign lane_nz[g] = |dn_sel[g*SW +: SW];
        end
    endgenerate

    AST_STB_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_stb && !dn_stall |=> !dn_stb);                                   // R5
    AST_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_stb && dn_stall |=> dn_stb && $stable(dn_adr) && $stable(dn_sel) && $stable(dn_wdat)); // R5
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |=> !up_ack);                                                // R7
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |-> $past(dn_ack) && $past(dn_cyc));                         // R7
    AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |-> !dn_cyc);                                                // R8
    AST_SEL_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_stb |-> $onehot0(lane_nz));                                      // R3
    AST_WDAT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        dn_stb |-> dn_wdat == {LANES{dn_wdat[UP_DW-1:0]}});                 // R4

endmodule

bind dmab_bridge dmab_chk #(.AW(AW), .UP_DW(UP_DW), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_ack   (up_ack),
    .dn_cyc   (dn_cyc),
    .dn_stb   (dn_stb),
    .dn_stall (dn_stall),
    .dn_ack   (dn_ack),
    .dn_adr   (dn_adr),
    .dn_sel   (dn_sel),
    .dn_wdat  (dn_wdat)
);

// File: tb/sim_dmab_bridge.sv
module sim_dmab_bridge;
    localparam int AW  = 30;
    localparam int DAW = AW - 1;

    typedef struct packed {
        logic            we;
        logic [DAW-1:0]  adr;
        logic [7:0]      sel;
        logic [63:0]     wdat;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 4 ns period

    logic           up_cyc = 0, up_stb = 0, up_we = 0;
    logic [AW-1:0]  up_adr = '0;
    logic [3:0]     up_sel = '0;
    logic [31:0]    up_wdat = '0;
    logic           up_ack;
    logic [31:0]    up_rdat;
    logic           dn_cyc, dn_stb, dn_we;
    logic [DAW-1:0] dn_adr;
    logic [7:0]     dn_sel;
    logic [63:0]    dn_wdat;
    logic           dn_stall = 0, dn_ack = 0;
    logic [63:0]    dn_rdat = '0;

    dmab_bridge #(.AW(AW), .UP_DW(32), .LANES(2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .up_cyc(up_cyc), .up_stb(up_stb), .up_we(up_we), .up_adr(up_adr),
        .up_sel(up_sel), .up_wdat(up_wdat), .up_ack(up_ack), .up_rdat(up_rdat),
        .dn_cyc(dn_cyc), .dn_stb(dn_stb), .dn_we(dn_we), .dn_adr(dn_adr),
        .dn_sel(dn_sel), .dn_wdat(dn_wdat), .dn_stall(dn_stall),
        .dn_ack(dn_ack), .dn_rdat(dn_rdat)
    );

    int   checks = 0;
    int   fails = 0;
    int   cfg_stall = 0;
    int   cfg_lat = 1;
    exp_t sb_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd_model(input logic [DAW-1:0] a);
        return {16'hA11A, a[15:0], 16'h0B0B, ~a[15:0]};
    endfunction

    // Downstream slave and scoreboard monitor
    initial begin
        int   stall_left = 0;
        int   stalled = 0;
        int   cd = 0;
        bit   pend = 0;
        bit   just = 0;
        bit   in_req = 0;
        exp_t cur;
        forever begin
            @(negedge clk);
            dn_ack = 1'b0;
            if (just) begin
                chk(!dn_stb, "R5", "strobe low after accept", 64'(dn_stb), 64'd0);
                just = 0;
            end
            if (pend) begin
                cd--;
                if (cd == 0) begin
                    chk(dn_cyc, "R5", "cyc held until ack", 64'(dn_cyc), 64'd1);
                    dn_ack  = 1'b1;
                    dn_rdat = rd_model(cur.adr);
                    pend    = 0;
                end
            end
            if (dn_stb) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R8", "strobe with nothing expected", 64'(dn_adr), 64'd0);
                    dn_stall = 1'b0;
                end else begin
                    if (!in_req) begin
                        in_req = 1;
                        stall_left = cfg_stall;
                        stalled = 0;
                        chk(!dn_ack && !up_ack, "R8", "strobe while previous in flight",
                            64'({dn_ack, up_ack}), 64'd0);
                    end
                    cur = sb_q[0];
                    chk(dn_adr == cur.adr, "R2", "dn_adr", 64'(dn_adr), 64'(cur.adr));
                    chk(dn_sel == cur.sel, "R3", "dn_sel", 64'(dn_sel), 64'(cur.sel));
                    chk(dn_we == cur.we && dn_wdat == cur.wdat, "R4", "we/wdat",
                        dn_wdat, cur.wdat);
                    if (stall_left > 0) begin
                        dn_stall = 1'b1;
                        stall_left--;
                        stalled++;
                    end else begin
                        dn_stall = 1'b0;
                        chk(stalled == cfg_stall, "R5", "strobe held through stall",
                            64'(stalled), 64'(cfg_stall));
                        void'(sb_q.pop_front());
                        pend = 1;
                        cd = cfg_lat;
                        just = 1;
                        in_req = 0;
                    end
                end
            end else begin
                dn_stall = 1'b0;
            end
        end
    end

    // Driver: pushes the expected downstream item, runs the classic handshake
    task automatic xfer(input bit we, input logic [AW-1:0] adr, input logic [3:0] sel,
                        input logic [31:0] wd, input int st, input int lat);
        exp_t        e;
        logic [63:0] m;
        int          n = 0;
        cfg_stall = st;
        cfg_lat   = lat;
        e.we   = we;
        e.adr  = adr[AW-1:1];
        e.sel  = adr[0] ? {sel, 4'h0} : {4'h0, sel};
        e.wdat = {wd, wd};
        sb_q.push_back(e);
        up_cyc = 1; up_stb = 1; up_we = we; up_adr = adr; up_sel = sel; up_wdat = wd;
        do begin @(negedge clk); n++; end while (!up_ack && n < 60);
        chk(up_ack, "R7", "ack received", 64'(up_ack), 64'd1);
        chk(n == st + lat + 2, "R10", "cycles to ack", 64'(n), 64'(st + lat + 2));
        if (!we) begin
            m = rd_model(adr[AW-1:1]);
            chk(up_rdat == (adr[0] ? m[63:32] : m[31:0]), "R6", "read lane",
                64'(up_rdat), adr[0] ? 64'(m[63:32]) : 64'(m[31:0]));
        end
        up_cyc = 0; up_stb = 0;
        @(negedge clk);
        chk(!up_ack, "R7", "ack one cycle wide", 64'(up_ack), 64'd0);
    endtask

    // Master withdraws, optionally followed at once by a new request
    task automatic abandon(input logic [AW-1:0] a_adr, input bit follow,
                           input logic [AW-1:0] b_adr);
        exp_t        e;
        logic [63:0] m;
        int          seen = 0;
        int          n = 0;
        cfg_stall = 4;
        cfg_lat   = 2;
        e.we = 0; e.adr = a_adr[AW-1:1];
        e.sel = a_adr[0] ? 8'hF0 : 8'h0F; e.wdat = '0;
        sb_q.push_back(e);
        up_cyc = 1; up_stb = 1; up_we = 0; up_adr = a_adr; up_sel = 4'hF; up_wdat = '0;
        @(negedge clk);
        @(negedge clk);
        up_cyc = 0; up_stb = 0;
        if (!follow) begin
            repeat (14) begin @(negedge clk); if (up_ack) seen++; end
            chk(seen == 0, "R9", "no ack after withdraw", 64'(seen), 64'd0);
            chk(sb_q.size() == 0, "R9", "downstream completed", 64'(sb_q.size()), 64'd0);
        end else begin
            @(negedge clk);
            e.adr = b_adr[AW-1:1];
            e.sel = b_adr[0] ? 8'hF0 : 8'h0F;
            sb_q.push_back(e);
            up_cyc = 1; up_stb = 1; up_adr = b_adr;
            do begin @(negedge clk); n++; if (up_ack) seen++; end while (!up_ack && n < 60);
            m = rd_model(b_adr[AW-1:1]);
            chk(seen == 1, "R9", "single ack for next transfer", 64'(seen), 64'd1);
            chk(up_rdat == (b_adr[0] ? m[63:32] : m[31:0]), "R9", "next transfer data",
                64'(up_rdat), b_adr[0] ? 64'(m[63:32]) : 64'(m[31:0]));
            up_cyc = 0; up_stb = 0;
            @(negedge clk);
            chk(!up_ack, "R7", "ack one cycle wide", 64'(up_ack), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!dn_cyc && !dn_stb && !up_ack, "R1", "quiet in reset",
            64'({dn_cyc, dn_stb, up_ack}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!dn_cyc && !dn_stb && !up_ack, "R1", "quiet after reset",
            64'({dn_cyc, dn_stb, up_ack}), 64'd0);

        xfer(1, 30'h0000_0010, 4'b1111, 32'hDEAD_BEEF, 0, 1);
        xfer(1, 30'h0000_0021, 4'b1010, 32'h1234_5678, 2, 1);
        xfer(0, 30'h0000_0040, 4'b1111, 32'h0, 0, 1);
        xfer(0, 30'h0000_0041, 4'b0011, 32'h0, 3, 3);
        for (int i = 0; i < 6; i++)
            xfer(i[0], AW'(30'h100 + i * 7), 4'(i + 1), 32'hA000_0000 + 32'(i), i % 3, 1 + i % 2);
        abandon(30'h0000_0200, 0, '0);
        abandon(30'h0000_0301, 1, 30'h0000_0450);
        xfer(0, 30'h0000_0555, 4'b1111, 32'h0, 1, 2);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule